// File: doc/BRIEF.md
# SCSI Target Receive Engine with Parity Check

This block is the target-side receiver of a parallel SCSI data phase in which the initiator drives the bus. Software loads a transfer length as "bytes minus one", picks a handshake mode and pulses `start`. The engine then produces exactly that many REQ cycles. It captures the eight data lines and the parity line each time the initiator asserts ACK, and it hands each byte to a ready/valid stream.

The two handshake modes share one counter and one capture path. In the interlocked (asynchronous) mode each REQ waits for ACK to be released and is held until ACK is asserted. In the paced (synchronous) mode REQ pulses come from a programmable on-time and period and do not wait for ACK. A small output queue and an in-flight counter act as the offset limit: a new REQ is issued only when every byte it could return has a free slot in the queue. Every captured byte gets an odd-parity check. A failure raises a sticky interrupt that only a dedicated clear input removes.

Top module: `scsi_rx_engine`

## Requirements
- R1: After `start` with `count_m1 = N`, the engine asserts `req_n` low exactly N+1 times and then stops, and `busy` falls once the last byte has been captured. `req_n` stays high whenever `busy` is low.
- R2: With `mode_sync = 0`, REQ is asserted only after the synchronized ACK is seen released (`ack_n` high). While `ack_n` is held low no REQ is asserted. Once asserted, REQ stays low until the byte is captured on ACK assertion, and then returns high.
- R3: With `mode_sync = 1`, each REQ low time is `max(assert_len,1)` cycles. Consecutive REQ falls are `max(assert_len,1) + max(period_len - max(assert_len,1), 1)` cycles apart, whatever ACK does, as long as queue space is available.
- R4: On each falling edge of `ack_n` seen through the `SYNC_STAGES` synchronizer, the engine captures `db_i[7:0]` and `dbp_i` together as one 9-bit sample.
- R5: Every captured byte appears on `out_data` in arrival order, whether its parity is good or bad. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R6: Parity is odd: a byte whose eight data bits plus `dbp_i` hold an even number of ones sets `par_err_irq`.
- R7: `par_err_irq` stays high until `irq_clr` is pulsed. A parity error in the same cycle as `irq_clr` keeps the flag set.
- R8: A new REQ is issued only while the count of REQs not yet answered plus the bytes held in the output queue is below `DEPTH`, so no byte is lost when the sink stalls.
- R9: `start` has no effect while `busy` is high. An ACK falling edge with no outstanding REQ (for example while idle) produces no output byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse, ignored while busy) |
| mode_sync | input | 1 | 0 = interlocked handshake, 1 = paced REQ pulses |
| count_m1 | input | CNT_W | Number of bytes to receive minus one |
| assert_len | input | TIM_W | Paced mode REQ low time in cycles |
| period_len | input | TIM_W | Paced mode REQ-to-REQ period in cycles |
| busy | output | 1 | Transfer in progress |
| req_n | output | 1 | REQ to the bus, active low |
| ack_n | input | 1 | ACK from the bus, active low, asynchronous |
| db_i | input | 8 | Data lines from the bus |
| dbp_i | input | 1 | Parity line from the bus |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Sink accepts the byte |
| par_err_irq | output | 1 | Sticky parity-error interrupt |
| irq_clr | input | 1 | Clears the interrupt |

## Verification
The assertions check on every cycle that the queue-plus-outstanding total never exceeds the depth and that a stalled output holds still. They also check that the interrupt is set after any bad-parity capture, stays set until cleared, and gives set priority over clear. In the interlocked mode they check that REQ is held until ACK arrives and is only asserted after ACK was seen released. Only the bench scenarios can show the exact number of REQ pulses per count, the paced on-time and period, the byte order and content across both modes, the throttling to the queue depth under a stalled sink, and that stray ACKs and repeated starts leave no trace.

// File: rtl/scsi_rx_pkg.sv
package scsi_rx_pkg;

    // Controller states shared by the engine and its checker
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A_WAIT,   // interlocked: wait for ACK released and queue credit
        ST_A_REQ,    // interlocked: REQ low, wait for ACK assertion
        ST_S_ARM,    // paced: waiting for queue credit
        ST_S_ON,     // paced: REQ low time
        ST_S_OFF,    // paced: REQ high time
        ST_DRAIN     // paced: all REQs issued, waiting for answers
    } rx_state_e;

endpackage

// File: rtl/scsi_rx_sync.sv
module scsi_rx_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    // One extra stage keeps the previous synchronized value for edge detection
    logic [STAGES:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s <= STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = stage_q[STAGES];

endmodule

// File: rtl/scsi_rx_parity.sv
module scsi_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_i,
    output logic              ok_o
);

    // Odd parity: total number of ones over data and parity bit must be odd
    logic [DATA_W:0] word;

    assign word = {par_i, data_i};
    assign ok_o = ^word;

endmodule

// File: rtl/scsi_rx_fifo.sv
module scsi_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [OCC_W-1:0] cnt;
    } fifo_ptr_t;

    fifo_ptr_t   ptr_d, ptr_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push_i) begin
            ptr_d.wr = (ptr_q.wr == LAST_PTR) ? '0 : ptr_q.wr + 1'b1;
        end
        if (pop_i) begin
            ptr_d.rd = (ptr_q.rd == LAST_PTR) ? '0 : ptr_q.rd + 1'b1;
        end
        ptr_d.cnt = ptr_q.cnt + OCC_W'(push_i) - OCC_W'(pop_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[ptr_q.wr] <= data_i;
        end
    end

    assign data_o  = mem_q[ptr_q.rd];
    assign valid_o = (ptr_q.cnt != '0);
    assign count_o = ptr_q.cnt;

endmodule

// File: rtl/scsi_rx_engine.sv
module scsi_rx_engine
    import scsi_rx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TIM_W       = 8,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_sync,
    input  logic [CNT_W-1:0] count_m1,
    input  logic [TIM_W-1:0] assert_len,
    input  logic [TIM_W-1:0] period_len,
    output logic             busy,
    output logic             req_n,
    input  logic             ack_n,
    input  logic [7:0]       db_i,
    input  logic             dbp_i,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             par_err_irq,
    input  logic             irq_clr
);

    localparam int DATA_W = 8;
    localparam int BUS_W  = DATA_W + 2;   // ack, parity, data
    localparam int OCC_W  = $clog2(DEPTH+1);
    localparam logic [OCC_W:0] DEPTH_V = (OCC_W+1)'(DEPTH);
    localparam logic [TIM_W-1:0] ONE_T = TIM_W'(1);

    typedef struct packed {
        rx_state_e        st;
        logic             req_n;
        logic             mode;
        logic [CNT_W-1:0] req_left;
        logic [TIM_W-1:0] tmr;
        logic [TIM_W-1:0] on_len;
        logic [TIM_W-1:0] off_len;
        logic [OCC_W-1:0] inflight;
        logic             irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Bus synchronizer: ACK and the nine sampled lines share one chain
    logic [BUS_W-1:0] bus_sync, bus_prev;
    logic             ack_s, ack_fall;
    logic [DATA_W-1:0] cap_data;
    logic             cap_par;

    scsi_rx_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ack_n, dbp_i, db_i}),
        .sync_o  (bus_sync),
        .prev_o  (bus_prev)
    );

    assign ack_s    = bus_sync[BUS_W-1];
    assign ack_fall = bus_prev[BUS_W-1] & ~ack_s;
    assign cap_par  = bus_sync[DATA_W];
    assign cap_data = bus_sync[DATA_W-1:0];

    // Parity check on the captured sample
    logic par_ok;

    scsi_rx_parity #(
        .DATA_W (DATA_W)
    ) u_par (
        .data_i (cap_data),
        .par_i  (cap_par),
        .ok_o   (par_ok)
    );

    // Output queue
    logic             push;
    logic             pop;
    logic [OCC_W-1:0] fifo_cnt;

    assign pop = out_valid & out_ready;

    scsi_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (cap_data),
        .pop_i   (pop),
        .data_o  (out_data),
        .valid_o (out_valid),
        .count_o (fifo_cnt)
    );

    // A byte is taken only when a REQ is waiting for its answer
    assign push = ack_fall & (ctl_q.inflight != '0);

    logic             credit;
    logic             issue;
    logic [TIM_W-1:0] on_w;
    logic [TIM_W-1:0] off_w;

    assign credit = ({1'b0, ctl_q.inflight} + {1'b0, fifo_cnt}) < DEPTH_V;
    assign on_w   = (assert_len == '0) ? ONE_T : assert_len;
    assign off_w  = (period_len > on_w) ? (period_len - on_w) : ONE_T;

    always_comb begin
        ctl_d = ctl_q;
        issue = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.mode     = mode_sync;
                    ctl_d.req_left = count_m1;
                    ctl_d.on_len   = on_w;
                    ctl_d.off_len  = off_w;
                    ctl_d.st       = mode_sync ? ST_S_ARM : ST_A_WAIT;
                end
            end
            ST_A_WAIT: begin
                if (ack_s && credit) begin
                    ctl_d.req_n = 1'b0;
                    issue       = 1'b1;
                    ctl_d.st    = ST_A_REQ;
                end
            end
            ST_A_REQ: begin
                if (push) begin
                    ctl_d.req_n = 1'b1;
                    if (ctl_q.req_left == '0) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.req_left = ctl_q.req_left - 1'b1;
                        ctl_d.st       = ST_A_WAIT;
                    end
                end
            end
            ST_S_ARM: begin
                if (credit) begin
                    ctl_d.req_n = 1'b0;
                    issue       = 1'b1;
                    ctl_d.tmr   = ctl_q.on_len - 1'b1;
                    ctl_d.st    = ST_S_ON;
                end
            end
            ST_S_ON: begin
                if (ctl_q.tmr == '0) begin
                    ctl_d.req_n = 1'b1;
                    if (ctl_q.req_left == '0) begin
                        ctl_d.st = ST_DRAIN;
                    end else begin
                        ctl_d.req_left = ctl_q.req_left - 1'b1;
                        ctl_d.tmr      = ctl_q.off_len - 1'b1;
                        ctl_d.st       = ST_S_OFF;
                    end
                end else begin
                    ctl_d.tmr = ctl_q.tmr - 1'b1;
                end
            end
            ST_S_OFF: begin
                if (ctl_q.tmr == '0) begin
                    if (credit) begin
                        ctl_d.req_n = 1'b0;
                        issue       = 1'b1;
                        ctl_d.tmr   = ctl_q.on_len - 1'b1;
                        ctl_d.st    = ST_S_ON;
                    end else begin
                        ctl_d.st = ST_S_ARM;
                    end
                end else begin
                    ctl_d.tmr = ctl_q.tmr - 1'b1;
                end
            end
            ST_DRAIN: begin
                if (ctl_q.inflight == '0) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.req_n = 1'b1;
            end
        endcase

        ctl_d.inflight = ctl_q.inflight + OCC_W'(issue) - OCC_W'(push);

        // Set wins over clear
        if (push && !par_ok) begin
            ctl_d.irq = 1'b1;
        end else if (irq_clr) begin
            ctl_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.req_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.st != ST_IDLE);
    assign req_n       = ctl_q.req_n;
    assign par_err_irq = ctl_q.irq;

    // Taps for the bound checker
    logic             mode_lat;
    logic [OCC_W-1:0] inflight_w;

    assign mode_lat   = ctl_q.mode;
    assign inflight_w = ctl_q.inflight;

endmodule

// File: rtl/scsi_rx_checker.sv
module scsi_rx_checker #(
    parameter int DEPTH = 4,
    parameter int OCC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mode_lat,
    input logic             req_n,
    input logic             ack_s,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             push,
    input logic             par_ok,
    input logic             par_err_irq,
    input logic             irq_clr,
    input logic [OCC_W-1:0] inflight_w,
    input logic [OCC_W-1:0] fifo_cnt
);

    // R8
    credit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(inflight_w) + 32'(fifo_cnt)) <= DEPTH);

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R6
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !par_ok) |=> par_err_irq);

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_irq && !irq_clr) |=> par_err_irq);

    // R7
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(push && !par_ok)) |=> !par_err_irq);

    // R1
    idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> req_n);

    // R2
    async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_lat && !req_n && ack_s) |=> !req_n);

    // R2
    async_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_lat && $fell(req_n)) |-> $past(ack_s));

endmodule

bind scsi_rx_engine scsi_rx_checker #(
    .DEPTH (DEPTH),
    .OCC_W (OCC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mode_lat    (mode_lat),
    .req_n       (req_n),
    .ack_s       (ack_s),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .push        (push),
    .par_ok      (par_ok),
    .par_err_irq (par_err_irq),
    .irq_clr     (irq_clr),
    .inflight_w  (inflight_w),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/scsi_rx_engine_bench.sv
module scsi_rx_engine_bench;

    localparam int CNT_W = 16;
    localparam int TIM_W = 8;
    localparam int DEPTH = 4;

    // Table row: {sync mode, count_m1, seed, bad-parity index (FF = none)}
    localparam int NROW = 5;
    localparam logic [24:0] VEC [NROW] = '{
        {1'b0, 8'd0, 8'hA5, 8'hFF},
        {1'b0, 8'd5, 8'h3C, 8'd2},
        {1'b1, 8'd9, 8'h00, 8'hFF},
        {1'b1, 8'd6, 8'hFF, 8'd6},
        {1'b0, 8'd2, 8'h81, 8'hFF}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             mode_sync = 1'b0;
    logic [CNT_W-1:0] count_m1 = '0;
    logic [TIM_W-1:0] assert_len = '0;
    logic [TIM_W-1:0] period_len = '0;
    logic             busy;
    logic             req_n;
    logic             ack_n = 1'b1;
    logic [7:0]       db_i = '0;
    logic             dbp_i = 1'b0;
    logic [7:0]       out_data;
    logic             out_valid;
    logic             rdy = 1'b1;
    logic             par_err_irq;
    logic             irq_clr = 1'b0;

    scsi_rx_engine #(
        .CNT_W (CNT_W),
        .TIM_W (TIM_W),
        .DEPTH (DEPTH)
    ) u_scsi_rx_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode_sync   (mode_sync),
        .count_m1    (count_m1),
        .assert_len  (assert_len),
        .period_len  (period_len),
        .busy        (busy),
        .req_n       (req_n),
        .ack_n       (ack_n),
        .db_i        (db_i),
        .dbp_i       (dbp_i),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_ready   (rdy),
        .par_err_irq (par_err_irq),
        .irq_clr     (irq_clr)
    );

    always #2 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int pulses = 0;
    int rx_cnt = 0;
    int tx_idx = 0;
    logic [7:0] cur_seed = '0;
    int  cur_bad  = 255;
    bit  resp_on  = 1'b0;
    bit  resp_sync = 1'b0;
    logic [7:0] got [64];

    function automatic logic [7:0] gen_byte(logic [7:0] s, int k);
        return s + 8'(k * 53);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_up();
        end
    end

    // REQ pulse counter
    always @(negedge req_n) pulses++;

    // Sink: handshake decided on stable values between edges
    always @(negedge clk) begin
        if (out_valid && rdy) begin
            if (rx_cnt < 64) got[rx_cnt] = out_data;
            rx_cnt++;
        end
    end

    // Initiator model
    always begin
        @(negedge req_n);
        if (resp_on) begin
            db_i  = gen_byte(cur_seed, tx_idx);
            dbp_i = ~(^gen_byte(cur_seed, tx_idx)) ^ (tx_idx == cur_bad);
            if (resp_sync) begin
                @(posedge clk); #1 ack_n = 1'b0;
                repeat (3) @(posedge clk);
                #1 ack_n = 1'b1;
            end else begin
                repeat (2) @(posedge clk);
                #1 ack_n = 1'b0;
                wait (req_n == 1'b1);
                @(posedge clk); #1 ack_n = 1'b1;
            end
            tx_idx++;
        end
    end

    task automatic do_start(bit sm, int cm1, int as_len, int per);
        @(posedge clk); #1;
        mode_sync  = sm;
        count_m1   = CNT_W'(cm1);
        assert_len = TIM_W'(as_len);
        period_len = TIM_W'(per);
        start      = 1'b1;
        @(posedge clk); #1;
        start      = 1'b0;
    endtask

    task automatic wait_idle(int lim);
        bit ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (!busy) begin
                ok = 1'b1;
                break;
            end
        end
        chk(ok, "R1 busy drops", int'(busy), 0);
        repeat (10) @(posedge clk);
        #1;
    endtask

    task automatic clear_irq();
        @(posedge clk); #1 irq_clr = 1'b1;
        @(posedge clk); #1 irq_clr = 1'b0;
    endtask

    task automatic prep(logic [7:0] seed, int bad, bit sm);
        cur_seed  = seed;
        cur_bad   = bad;
        resp_sync = sm;
        resp_on   = 1'b1;
        tx_idx    = 0;
        rx_cnt    = 0;
        pulses    = 0;
    endtask

    function automatic int mismatches(logic [7:0] seed, int n);
        int m = 0;
        for (int k = 0; k < n; k++) begin
            if (got[k] != gen_byte(seed, k)) m++;
        end
        return m;
    endfunction

    initial begin
        int w_on;
        int w_per;
        int mm;
        bit seen;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // Reset state
        chk(req_n == 1'b1, "R1 reset req_n", int'(req_n), 1);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(out_valid == 1'b0, "R5 reset out_valid", int'(out_valid), 0);
        chk(par_err_irq == 1'b0, "R7 reset irq", int'(par_err_irq), 0);

        // R9: stray ACK while idle yields no byte
        ack_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 ack_n = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        chk(!out_valid && rx_cnt == 0, "R9 stray ack", rx_cnt, 0);

        // Table walk
        for (int r = 0; r < NROW; r++) begin
            bit  sm   = VEC[r][24];
            int  cm1  = int'(VEC[r][23:16]);
            int  bad  = int'(VEC[r][7:0]);
            bit  eirq = (VEC[r][7:0] != 8'hFF);
            prep(VEC[r][15:8], bad, sm);
            do_start(sm, cm1, 3, 8);
            wait_idle(5000);
            chk(pulses == cm1 + 1, "R1 req count", pulses, cm1 + 1);
            chk(rx_cnt == cm1 + 1, "R5 byte count", rx_cnt, cm1 + 1);
            mm = mismatches(VEC[r][15:8], cm1 + 1);
            chk(mm == 0, "R4 byte content", mm, 0);
            chk(par_err_irq == eirq, "R6 parity flag", int'(par_err_irq), int'(eirq));
            clear_irq();
            chk(par_err_irq == 1'b0, "R7 flag cleared", int'(par_err_irq), 0);
        end

        // R3: paced timing, normal period
        prep(8'h11, 255, 1'b1);
        do_start(1'b1, 3, 3, 9);
        @(negedge req_n);
        w_on = 0;
        do begin @(posedge clk); #1; w_on++; end while (req_n == 1'b0);
        w_per = w_on;
        do begin @(posedge clk); #1; w_per++; end while (req_n == 1'b1);
        chk(w_on == 3, "R3 on time", w_on, 3);
        chk(w_per == 9, "R3 period", w_per, 9);
        wait_idle(2000);

        // R3: period shorter than on time gives a one-cycle gap
        prep(8'h22, 255, 1'b1);
        do_start(1'b1, 3, 5, 3);
        @(negedge req_n);
        w_on = 0;
        do begin @(posedge clk); #1; w_on++; end while (req_n == 1'b0);
        w_per = w_on;
        do begin @(posedge clk); #1; w_per++; end while (req_n == 1'b1);
        chk(w_on == 5, "R3 long on time", w_on, 5);
        chk(w_per == 6, "R3 min gap period", w_per, 6);
        wait_idle(2000);

        // R8: stalled sink throttles REQ to the queue depth
        prep(8'h47, 255, 1'b1);
        rdy = 1'b0;
        do_start(1'b1, 7, 2, 6);
        repeat (300) @(posedge clk);
        #1;
        chk(pulses == DEPTH, "R8 throttled reqs", pulses, DEPTH);
        chk(out_valid == 1'b1, "R5 held valid", int'(out_valid), 1);
        rdy = 1'b1;
        wait_idle(3000);
        chk(rx_cnt == 8, "R8 no byte lost", rx_cnt, 8);
        mm = mismatches(8'h47, 8);
        chk(mm == 0, "R5 order after stall", mm, 0);

        // R2: interlock with a manually driven ACK
        resp_on = 1'b0;
        rx_cnt  = 0;
        ack_n   = 1'b0;
        do_start(1'b0, 0, 0, 0);
        repeat (30) @(posedge clk);
        #1;
        chk(req_n == 1'b1, "R2 no req while ack low", int'(req_n), 1);
        ack_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            if (!req_n) begin seen = 1'b1; break; end
        end
        chk(seen, "R2 req after ack release", int'(seen), 1);
        repeat (20) @(posedge clk);
        #1;
        chk(req_n == 1'b0, "R2 req held", int'(req_n), 0);
        db_i  = 8'h5A;
        dbp_i = ~(^8'h5A);
        repeat (2) @(posedge clk);
        #1 ack_n = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            if (req_n) begin seen = 1'b1; break; end
        end
        chk(seen, "R2 req released on ack", int'(seen), 1);
        ack_n = 1'b1;
        wait_idle(100);
        chk(rx_cnt == 1 && got[0] == 8'h5A, "R4 manual sample", int'(got[0]), 8'h5A);
        chk(par_err_irq == 1'b0, "R6 good parity no flag", int'(par_err_irq), 0);

        // R9: start while busy is ignored
        prep(8'h63, 255, 1'b1);
        do_start(1'b1, 2, 3, 8);
        repeat (5) @(posedge clk);
        do_start(1'b0, 9, 3, 8);
        wait_idle(2000);
        chk(pulses == 3, "R9 restart ignored", pulses, 3);

        finish_up();
    end

endmodule